// File: doc/BRIEF.md
# Fallback Controller Serial Register Port

This block is the serial access port through which user logic configures and queries a dual-image fallback controller. A 41-bit shift chain sits between a serial data input and a serial data output. The two high bits of the chain are a source selector. The low 39 bits are the data field. A 39-bit input register holds the settings that user logic writes. Three read-only sources can be captured: the controller's current-state word, and the two most recent reconfiguration-event records. The port keeps those two records itself, in a two-deep history.

Two mode controls pick one operation per rising clock: shift, capture or update. A third input marks user mode, and nothing in the port moves outside user mode. To read a register, user logic shifts in a 41-bit word whose top two bits name the source. It then issues one capture, and shifts the 39 data bits out, least significant bit first. To write, it shifts in a word and issues one update. The image-select bit and the select-override bit of the input register go straight to the controller.

The operation decoder has four states, re-decoded on every clock from the inputs. `OP_HOLD` applies whenever user mode is low. `OP_SHIFT` applies when shift is high. `OP_CAPTURE` applies when shift is low and capture is high. `OP_UPDATE` applies when both controls are low. Any state can follow any other on the next clock. The capture source is a second decoded value taken from chain bits 40:39: `SRC_NOW`=00, `SRC_REC1`=01, `SRC_REC2`=10 and `SRC_INREG`=11.

Top module: `upg_regport`

## Requirements
- R1: With user mode high and `mode_shift` high, each rising clock moves the whole 41-bit chain one place toward bit 0 and loads `sdin` into bit 40. `mode_capture` has no effect in this case.
- R2: `sdout` always equals chain bit 0, so it is valid right after every shift and every capture.
- R3: With user mode high and both controls low, one clock copies chain bit 13 into the image select (`img_sel`) and chain bit 12 into the select override (`sel_override`). The chain does not change.
- R4: The input register reads as zero in bits 38:14 and 11:0, whatever was shifted into those positions before an update.
- R5: With user mode high, `mode_shift` low and `mode_capture` high, one clock loads chain bits 38:0 from the source named by chain bits 40:39 (00 current state, 01 record 1, 10 record 2, 11 input register). Bits 40:39 are kept.
- R6: The current-state word has the controller state in bits 33:30, the watchdog enable in bit 29, the 29-bit timeout in bits 28:0, and zeros in bits 38:34.
- R7: An event record is 32 bits, zero-extended to 39 bits on capture. Bits 31:28 hold the cause as one-hot, keeping only the highest set bit of `ev_cause`: bit 3 external reconfigure, bit 2 integrity error, bit 1 status pin, bit 0 watchdog. Bits 25:22 hold `ctl_state` at the event. All other bits are zero.
- R8: On each `ev_log` clock, record 2 takes the old record 1 and record 1 takes the new record. Captures in the same clock see the old records.
- R9: While `user_mode` is low, the chain, `sdout`, `img_sel` and `sel_override` hold their values. Events are still logged.
- R10: An active-low `rst_n` clears the chain, the input register and both records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | High when the device is in user mode; enables the port |
| sdin | input | 1 | Serial data into chain bit 40 |
| mode_shift | input | 1 | Shift-not-load control |
| mode_capture | input | 1 | Capture-not-update control (used when shift is low) |
| sdout | output | 1 | Serial data out, chain bit 0 |
| ctl_state | input | 4 | Controller state, for the current-state word and event records |
| wd_en | input | 1 | Watchdog enable, for the current-state word |
| wd_tmo | input | 29 | Watchdog timeout value, for the current-state word |
| ev_log | input | 1 | One-clock strobe: log a reconfiguration event |
| ev_cause | input | 4 | Event cause bits, priority highest bit first |
| img_sel | output | 1 | Input register image select (bit 13) |
| sel_override | output | 1 | Input register select-pin override (bit 12) |

## Verification
The hardest state to reach is a record 2 that differs from record 1 and can be read back through the serial port. It needs two events with different causes and states. After them, the source bits must be placed by a full 41-bit shift, then one capture, then 39 shifts to read the data out. The bench logs two events whose causes have several bits set. It then reads both records and checks the one-hot priority and the ageing. Reserved input-register bits are driven by shifting an all-ones word before an update, and are then read back through the input-register source.

// File: rtl/upg_pkg.sv
package upg_pkg;
    localparam int CHAIN_W   = 41;
    localparam int SEL_W     = 2;
    localparam int DATA_W    = CHAIN_W - SEL_W;
    localparam int ST_W      = 4;
    localparam int TMO_W     = 29;
    localparam int CAUSE_W   = 4;
    localparam int REC_W     = 32;
    localparam int REC_C_LSB = 28;
    localparam int REC_S_LSB = 22;
    localparam int IMG_BIT   = 13;
    localparam int OVR_BIT   = 12;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_UPDATE  = 2'd2,
        OP_CAPTURE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SRC_NOW   = 2'd0,
        SRC_REC1  = 2'd1,
        SRC_REC2  = 2'd2,
        SRC_INREG = 2'd3
    } src_e;
endpackage

// File: rtl/upg_mode_dec.sv
module upg_mode_dec
    import upg_pkg::*;
(
    input  logic user_mode,
    input  logic mode_shift,
    input  logic mode_capture,
    output op_e  op
);
    always_comb begin
        unique casez ({user_mode, mode_shift, mode_capture})
            3'b0??:  op = OP_HOLD;
            3'b11?:  op = OP_SHIFT;
            3'b101:  op = OP_CAPTURE;
            3'b100:  op = OP_UPDATE;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/upg_shift_chain.sv
module upg_shift_chain
    import upg_pkg::*;
#(
    parameter int CW = CHAIN_W,
    parameter int SW = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic             din,
    input  logic [CW-SW-1:0] src_now,
    input  logic [CW-SW-1:0] src_rec1,
    input  logic [CW-SW-1:0] src_rec2,
    input  logic [CW-SW-1:0] src_inreg,
    output logic [CW-1:0]    chain
);
    localparam int DW = CW - SW;

    src_e            src;
    logic [DW-1:0]   cap_word;

    assign src = src_e'(chain[CW-1 -: SW]);

    always_comb begin
        unique case (src)
            SRC_NOW:   cap_word = src_now;
            SRC_REC1:  cap_word = src_rec1;
            SRC_REC2:  cap_word = src_rec2;
            SRC_INREG: cap_word = src_inreg;
            default:   cap_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            unique case (op)
                OP_SHIFT:   chain <= {din, chain[CW-1:1]};
                OP_CAPTURE: chain[DW-1:0] <= cap_word;
                OP_UPDATE:  chain <= chain;
                OP_HOLD:    chain <= chain;
                default:    chain <= chain;
            endcase
        end
    end

    // R1: shift moves the chain and loads din at the top
    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (chain == {$past(din), $past(chain[CW-1:1])}));

    // R5: capture keeps the selector bits
    p_capsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE) |=> $stable(chain[CW-1 -: SW]));

    // R5: selector 11 returns the input register
    p_capir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE && chain[CW-1 -: SW] == 2'b11)
        |=> (chain[DW-1:0] == $past(src_inreg)));

    // R3, R9: update and hold leave the chain alone
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD || op == OP_UPDATE) |=> $stable(chain));
endmodule

// File: rtl/upg_inreg.sv
module upg_inreg
    import upg_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int IMGB = IMG_BIT,
    parameter int OVRB = OVR_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic          upd_img,
    input  logic          upd_ovr,
    output logic          img_sel,
    output logic          sel_ovr,
    output logic [DW-1:0] inreg_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_sel <= 1'b0;
            sel_ovr <= 1'b0;
        end else if (op == OP_UPDATE) begin
            img_sel <= upd_img;
            sel_ovr <= upd_ovr;
        end
    end

    always_comb begin
        inreg_word       = '0;
        inreg_word[IMGB] = img_sel;
        inreg_word[OVRB] = sel_ovr;
    end

    // R3: update takes the image select from the chain
    p_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE) |=> (img_sel == $past(upd_img) && sel_ovr == $past(upd_ovr)));

    // R9: no update, no change
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_UPDATE) |=> ($stable(img_sel) && $stable(sel_ovr)));
endmodule

// File: rtl/upg_history.sv
module upg_history
    import upg_pkg::*;
#(
    parameter int STW  = ST_W,
    parameter int CAW  = CAUSE_W,
    parameter int RW   = REC_W,
    parameter int CLSB = REC_C_LSB,
    parameter int SLSB = REC_S_LSB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_log,
    input  logic [CAW-1:0] ev_cause,
    input  logic [STW-1:0] ev_state,
    output logic [RW-1:0]  rec1,
    output logic [RW-1:0]  rec2
);
    logic [CAW-1:0] win;
    logic [RW-1:0]  new_rec;

    always_comb begin
        win = '0;
        for (int i = 0; i < CAW; i++) begin
            if (ev_cause[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        end
    end

    always_comb begin
        new_rec                 = '0;
        new_rec[CLSB +: CAW]    = win;
        new_rec[SLSB +: STW]    = ev_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec1 <= '0;
            rec2 <= '0;
        end else if (ev_log) begin
            rec2 <= rec1;
            rec1 <= new_rec;
        end
    end

    // R8: the older record ages into the second slot
    p_age_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_log |=> (rec2 == $past(rec1)));

    // R7: at most one cause bit is recorded
    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_log |=> $onehot0(rec1[CLSB +: CAW]));

    // R7: the top cause bit wins a tie
    p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_log && ev_cause[CAW-1]) |=> rec1[CLSB+CAW-1]);
endmodule

// File: rtl/upg_regport.sv
module upg_regport
    import upg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode,
    input  logic             sdin,
    input  logic             mode_shift,
    input  logic             mode_capture,
    output logic             sdout,
    input  logic [ST_W-1:0]  ctl_state,
    input  logic             wd_en,
    input  logic [TMO_W-1:0] wd_tmo,
    input  logic             ev_log,
    input  logic [CAUSE_W-1:0] ev_cause,
    output logic             img_sel,
    output logic             sel_override
);
    localparam int NOW_W = ST_W + 1 + TMO_W;

    op_e                op;
    logic [CHAIN_W-1:0] chain;
    logic [DATA_W-1:0]  now_word;
    logic [DATA_W-1:0]  rec1_word;
    logic [DATA_W-1:0]  rec2_word;
    logic [DATA_W-1:0]  inreg_word;
    logic [REC_W-1:0]   rec1;
    logic [REC_W-1:0]   rec2;

    upg_mode_dec u_dec (
        .user_mode   (user_mode),
        .mode_shift  (mode_shift),
        .mode_capture(mode_capture),
        .op          (op)
    );

    assign now_word  = {{(DATA_W-NOW_W){1'b0}}, ctl_state, wd_en, wd_tmo};
    assign rec1_word = {{(DATA_W-REC_W){1'b0}}, rec1};
    assign rec2_word = {{(DATA_W-REC_W){1'b0}}, rec2};

    upg_shift_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .din      (sdin),
        .src_now  (now_word),
        .src_rec1 (rec1_word),
        .src_rec2 (rec2_word),
        .src_inreg(inreg_word),
        .chain    (chain)
    );

    upg_inreg u_inreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .upd_img   (chain[IMG_BIT]),
        .upd_ovr   (chain[OVR_BIT]),
        .img_sel   (img_sel),
        .sel_ovr   (sel_override),
        .inreg_word(inreg_word)
    );

    upg_history u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_log  (ev_log),
        .ev_cause(ev_cause),
        .ev_state(ctl_state),
        .rec1    (rec1),
        .rec2    (rec2)
    );

    assign sdout = chain[0];

    // R9: outside user mode the serial output holds
    p_sdout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode) |=> $stable(sdout));
endmodule

// File: tb/upg_regport_test.sv
module upg_regport_test;
    localparam int CLK_P = 10;
    localparam int WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_mode = 1'b0;
    logic        sdin = 1'b0;
    logic        mode_shift = 1'b1;
    logic        mode_capture = 1'b0;
    logic        sdout;
    logic [3:0]  ctl_state = 4'd0;
    logic        wd_en = 1'b0;
    logic [28:0] wd_tmo = '0;
    logic        ev_log = 1'b0;
    logic [3:0]  ev_cause = 4'd0;
    logic        img_sel;
    logic        sel_override;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    string tag = "R10 reset";

    // reference state
    logic [40:0] m_sr;
    logic        m_img, m_ovr;
    logic [31:0] m_r1, m_r2;

    upg_regport uut (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .sdin(sdin),
        .mode_shift(mode_shift), .mode_capture(mode_capture), .sdout(sdout),
        .ctl_state(ctl_state), .wd_en(wd_en), .wd_tmo(wd_tmo),
        .ev_log(ev_log), .ev_cause(ev_cause),
        .img_sel(img_sel), .sel_override(sel_override)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] make_rec(input logic [3:0] c, input logic [3:0] s);
        logic [31:0] r;
        int top;
        r = '0;
        top = -1;
        for (int i = 0; i < 4; i++) if (c[i]) top = i;
        if (top >= 0) r[28 + top] = 1'b1;
        r[25:22] = s;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sr = '0; m_img = 1'b0; m_ovr = 1'b0; m_r1 = '0; m_r2 = '0;
        end else begin
            if (user_mode) begin
                if (mode_shift) m_sr = {sdin, m_sr[40:1]};
                else if (mode_capture) begin
                    case (m_sr[40:39])
                        2'b00: m_sr[38:0] = {5'b0, ctl_state, wd_en, wd_tmo};
                        2'b01: m_sr[38:0] = {7'b0, m_r1};
                        2'b10: m_sr[38:0] = {7'b0, m_r2};
                        default: m_sr[38:0] = 39'(m_img) << 13 | 39'(m_ovr) << 12;
                    endcase
                end else begin
                    m_img = m_sr[13];
                    m_ovr = m_sr[12];
                end
            end
            if (ev_log) begin
                m_r2 = m_r1;
                m_r1 = make_rec(ev_cause, ctl_state);
            end
        end
    end

    task automatic check(input string t, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", t, what, got, exp);
        end
    endtask

    // R2 and others: compare every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!done) begin
            check(tag, "sdout R2", 64'(sdout), 64'(m_sr[0]));
            check(tag, "img_sel", 64'(img_sel), 64'(m_img));
            check(tag, "sel_override", 64'(sel_override), 64'(m_ovr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD_LIMIT && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp=<%0d", cycles, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input logic d, input logic s, input logic c);
        @(negedge clk);
        sdin = d; mode_shift = s; mode_capture = c;
    endtask

    task automatic load41(input logic [40:0] v);
        for (int i = 0; i < 41; i++) cyc(v[i], 1'b1, i[0]);
    endtask

    task automatic read39(output logic [38:0] w);
        for (int i = 0; i < 39; i++) begin
            @(negedge clk);
            w[i] = sdout;
            sdin = 1'b0; mode_shift = 1'b1; mode_capture = 1'b0;
        end
    endtask

    task automatic logev(input logic [3:0] c, input logic [3:0] s);
        @(negedge clk);
        ev_log = 1'b1; ev_cause = c; ctl_state = s;
        @(negedge clk);
        ev_log = 1'b0; ev_cause = 4'd0;
    endtask

    task automatic read_src(input logic [1:0] s, output logic [38:0] w);
        load41({s, 39'h0});
        cyc(1'b0, 1'b0, 1'b1);
        read39(w);
    endtask

    logic [38:0] w;
    logic        keep_img, keep_out;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "sdout reset", 64'(sdout), 64'd0);
        check("R10", "img reset", 64'(img_sel), 64'd0);
        rst_n = 1'b1;
        user_mode = 1'b1;

        // R1 R2: shift patterns with capture toggling
        tag = "R1 shift";
        load41(41'h0_A5C3_1F00_7E);
        load41(41'h1_5A3C_E0FF_81);

        // R3 R4: all-ones update, reserved bits dropped
        tag = "R3 update";
        load41({2'b11, 39'h7F_FFFF_FFFF});
        cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3", "img after update", 64'(img_sel), 64'd1);
        check("R3", "ovr after update", 64'(sel_override), 64'd1);
        tag = "R4 reserved";
        read_src(2'b11, w);
        check("R4", "inreg readback", 64'(w), 64'h3000);
        // clear override only
        tag = "R3 update";
        load41({2'b11, 39'h2000});
        cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3", "ovr cleared", 64'(sel_override), 64'd0);

        // R5 R6: current-state word
        tag = "R6 now word";
        ctl_state = 4'hB; wd_en = 1'b1; wd_tmo = 29'h1A5A_5C3C;
        read_src(2'b00, w);
        check("R6", "now word", 64'(w), 64'({5'b0, 4'hB, 1'b1, 29'h1A5A_5C3C}));
        ctl_state = 4'h2; wd_en = 1'b0; wd_tmo = 29'h0000_0001;
        read_src(2'b00, w);
        check("R5", "now word 2", 64'(w), 64'({5'b0, 4'h2, 1'b0, 29'h1}));

        // R7 R8: two events, read both records
        tag = "R7 records";
        logev(4'b0110, 4'h5);
        logev(4'b1001, 4'h3);
        read_src(2'b01, w);
        check("R7", "record 1", 64'(w), 64'({7'b0, 4'b1000, 2'b0, 4'h3, 22'h0}));
        tag = "R8 ageing";
        read_src(2'b10, w);
        check("R8", "record 2", 64'(w), 64'({7'b0, 4'b0100, 2'b0, 4'h5, 22'h0}));

        // R9: user mode off, nothing moves, event still logged
        tag = "R9 hold";
        load41({2'b11, 39'h2000});
        cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        keep_img = img_sel;
        keep_out = sdout;
        user_mode = 1'b0;
        load41(41'h0_0000_0000_00);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        logev(4'b0001, 4'h9);
        @(negedge clk);
        check("R9", "img held", 64'(img_sel), 64'(keep_img));
        check("R9", "sdout held", 64'(sdout), 64'(keep_out));
        user_mode = 1'b1;
        read_src(2'b01, w);
        check("R9", "logged while idle", 64'(w), 64'({7'b0, 4'b0001, 2'b0, 4'h9, 22'h0}));

        // R10: reset mid-run clears records and input register
        tag = "R10 reset";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "img after reset", 64'(img_sel), 64'd0);
        rst_n = 1'b1;
        read_src(2'b01, w);
        check("R10", "record cleared", 64'(w), 64'd0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule